// File: doc/BRIEF.md
# Latched Address One-of-Eight Decoder

This block turns a 3-bit select value into eight active-low lines, exactly one of which is driven low for the address held in an internal address store. A latch control, active low, decides whether the store follows the select input or freezes it. While that control is sampled low, each new address is taken in and decoded. Once it is sampled high, the store keeps the last address taken and later changes on the select input do nothing.

Two output enables of opposite polarity sit after the store. If either is in its inactive state, all eight lines are forced high at once, in the same cycle, without a clock edge. The stored address is not touched, so releasing the enables brings back the decode of whatever the store holds. Everything is synchronous to one clock, with a synchronous active-high reset.

The store is run by a small state machine with three states. `LS_BLANK` is entered by reset and keeps every line high. `LS_FOLLOW` is entered on any clock at which the latch control is sampled low: the `load` transition copies the select input into the store. `LS_HOLD` is entered on any clock at which the latch control is sampled high: the `freeze` transition keeps the store as it is. Both transitions can be taken from every state.

Top module: `addr_latched_decoder`

## Requirements
- R1: While reset is asserted, all eight outputs are high. The first clock after reset with the latch control high leaves the stored address at 0, so output 0 goes low if both enables are active.
- R2: Output index i (bit i of `y_n`) is low exactly when the stored address equals i, where `sel[2]` has weight 4, `sel[1]` weight 2 and `sel[0]` weight 1. No more than one output is ever low.
- R3: At a clock edge where `le_n` is sampled low, the store takes the `sel` value sampled at that edge, and the outputs show its decode after that edge.
- R4: At a clock edge where `le_n` is sampled high, the store keeps its value whatever `sel` is.
- R5: After `le_n` rises, the retained address is the one sampled at the last edge where `le_n` was low.
- R6: While `oe_hi` is low, all outputs are high. This takes effect in the same cycle and does not depend on `le_n`.
- R7: While `oe_lo_n` is high, all outputs are high. This takes effect in the same cycle and does not depend on `le_n`.
- R8: The enables never change the stored address. When they are released, the outputs again show the decode of the stored address.
- R9: If `le_n` toggles on consecutive clocks, every edge with `le_n` sampled low loads a new address, and every edge with `le_n` high in between holds it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 3 | Select address |
| le_n | input | 1 | Latch control, active low: low loads, high holds |
| oe_hi | input | 1 | Output enable, active high |
| oe_lo_n | input | 1 | Output enable, active low |
| y_n | output | 8 | Decoded lines, active low |

## Verification
Several properties are checked on every cycle. No more than one line is low. Each enable blanks all lines while it is inactive. The store follows the sampled select value on every low latch control and keeps its value on every high one. Other behaviour only shows up in the bench's ordered scenarios: which address survives a rising latch control, that the decode of the stored address returns after the enables have blanked it, the output state right after reset, and loading on alternating clocks.

// File: rtl/addr_latched_decoder_pkg.sv
`timescale 1ns/1ps
package addr_latched_decoder_pkg;
    typedef enum logic [1:0] {
        LS_BLANK  = 2'd0,
        LS_FOLLOW = 2'd1,
        LS_HOLD   = 2'd2
    } latch_state_e;
endpackage

// File: rtl/addr_store_fsm.sv
`timescale 1ns/1ps
module addr_store_fsm
    import addr_latched_decoder_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             le_n,
    output logic [SEL_W-1:0] stored,
    output logic             valid
);
    latch_state_e state, next_state;

    // next-state choice: load on low control, freeze on high control
    always_comb begin
        next_state = state;
        unique case (state)
            LS_BLANK:  next_state = le_n ? LS_HOLD : LS_FOLLOW;
            LS_FOLLOW: next_state = le_n ? LS_HOLD : LS_FOLLOW;
            LS_HOLD:   next_state = le_n ? LS_HOLD : LS_FOLLOW;
            default:   next_state = LS_BLANK;
        endcase
    end

    // state register together with the address store
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= LS_BLANK;
            stored <= '0;
        end else begin
            state <= next_state;
            if (next_state == LS_FOLLOW)
                stored <= sel;
        end
    end

    // outputs of the machine
    always_comb begin
        unique case (state)
            LS_BLANK:  valid = 1'b0;
            LS_FOLLOW: valid = 1'b1;
            LS_HOLD:   valid = 1'b1;
            default:   valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/onehot_low_decoder.sv
`timescale 1ns/1ps
module onehot_low_decoder #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] addr,
    output logic [LINES-1:0] dec_n
);
    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign dec_n[i] = (addr == SEL_W'(i)) ? 1'b0 : 1'b1;
    end
endmodule

// File: rtl/line_enable_gate.sv
`timescale 1ns/1ps
module line_enable_gate #(
    parameter int LINES = 8
) (
    input  logic [LINES-1:0] dec_n,
    input  logic             valid,
    input  logic             oe_hi,
    input  logic             oe_lo_n,
    output logic [LINES-1:0] y_n
);
    logic pass;
    assign pass = valid & oe_hi & ~oe_lo_n;
    assign y_n  = pass ? dec_n : '1;
endmodule

// File: rtl/addr_latched_decoder.sv
`timescale 1ns/1ps
module addr_latched_decoder #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] sel,
    input  logic             le_n,
    input  logic             oe_hi,
    input  logic             oe_lo_n,
    output logic [LINES-1:0] y_n
);
    logic [SEL_W-1:0] stored_addr;
    logic             store_valid;
    logic [LINES-1:0] dec_n;

    addr_store_fsm #(.SEL_W(SEL_W)) u_store (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .le_n   (le_n),
        .stored (stored_addr),
        .valid  (store_valid)
    );

    onehot_low_decoder #(.SEL_W(SEL_W)) u_dec (
        .addr  (stored_addr),
        .dec_n (dec_n)
    );

    line_enable_gate #(.LINES(LINES)) u_gate (
        .dec_n   (dec_n),
        .valid   (store_valid),
        .oe_hi   (oe_hi),
        .oe_lo_n (oe_lo_n),
        .y_n     (y_n)
    );
endmodule

// File: rtl/addr_latched_decoder_chk.sv
`timescale 1ns/1ps
module addr_latched_decoder_chk #(
    parameter int SEL_W = 3,
    localparam int LINES = 1 << SEL_W
) (
    input logic             clk,
    input logic             rst,
    input logic [SEL_W-1:0] sel,
    input logic             le_n,
    input logic             oe_hi,
    input logic             oe_lo_n,
    input logic [LINES-1:0] y_n,
    input logic [SEL_W-1:0] stored
);
    // R2
    at_most_one_low_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~y_n));

    // R3
    load_on_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(le_n)) |-> (stored == $past(sel)));

    // R4
    hold_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(le_n)) |-> $stable(stored));

    // R6
    oe_hi_blank_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_hi |-> (y_n == '1));

    // R7
    oe_lo_blank_chk: assert property (@(posedge clk) disable iff (rst)
        oe_lo_n |-> (y_n == '1));
endmodule

bind addr_latched_decoder addr_latched_decoder_chk #(.SEL_W(SEL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sel     (sel),
    .le_n    (le_n),
    .oe_hi   (oe_hi),
    .oe_lo_n (oe_lo_n),
    .y_n     (y_n),
    .stored  (stored_addr)
);

// File: tb/test_addr_latched_decoder.sv
`timescale 1ns/1ps
module test_addr_latched_decoder;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] sel;
    logic       le_n;
    logic       oe_hi;
    logic       oe_lo_n;
    logic [7:0] y_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    addr_latched_decoder i_addr_latched_decoder (
        .clk(clk), .rst(rst), .sel(sel), .le_n(le_n),
        .oe_hi(oe_hi), .oe_lo_n(oe_lo_n), .y_n(y_n)
    );

    // entry: {req[3:0], le_n, sel[2:0], oe_hi, oe_lo_n, expected y_n[7:0]}
    localparam int NVEC = 16;
    localparam logic [17:0] VEC [NVEC] = '{
        {4'd3, 1'b0, 3'd5, 1'b1, 1'b0, 8'hDF},  // R3 load 5
        {4'd3, 1'b0, 3'd2, 1'b1, 1'b0, 8'hFB},  // R3 load 2
        {4'd5, 1'b1, 3'd7, 1'b1, 1'b0, 8'hFB},  // R5 rise keeps 2
        {4'd4, 1'b1, 3'd4, 1'b1, 1'b0, 8'hFB},  // R4 sel ignored
        {4'd6, 1'b1, 3'd4, 1'b0, 1'b0, 8'hFF},  // R6 blank while held
        {4'd7, 1'b1, 3'd1, 1'b1, 1'b1, 8'hFF},  // R7 blank while held
        {4'd8, 1'b1, 3'd1, 1'b1, 1'b0, 8'hFB},  // R8 stored 2 returns
        {4'd9, 1'b0, 3'd3, 1'b1, 1'b0, 8'hF7},  // R9 toggle load 3
        {4'd9, 1'b1, 3'd6, 1'b1, 1'b0, 8'hF7},  // R9 toggle hold
        {4'd9, 1'b0, 3'd6, 1'b1, 1'b0, 8'hBF},  // R9 toggle load 6
        {4'd9, 1'b1, 3'd0, 1'b1, 1'b0, 8'hBF},  // R9 toggle hold
        {4'd6, 1'b0, 3'd0, 1'b0, 1'b0, 8'hFF},  // R6 blank while loading 0
        {4'd8, 1'b1, 3'd7, 1'b1, 1'b0, 8'hFE},  // R8 stored 0 shows
        {4'd2, 1'b0, 3'd7, 1'b1, 1'b0, 8'h7F},  // R2 top line
        {4'd7, 1'b0, 3'd1, 1'b0, 1'b1, 8'hFF},  // R7 both off, load 1
        {4'd8, 1'b1, 3'd4, 1'b1, 1'b0, 8'hFD}   // R8 stored 1 shows
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: y_n=%h expected %h", req, act, exp);
        end
    endtask

    initial begin
        rst = 1'b1; le_n = 1'b1; sel = 3'd0; oe_hi = 1'b1; oe_lo_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", y_n, 8'hFF);
        rst = 1'b0;
        @(posedge clk); #2;
        check("R1 first hold", y_n, 8'hFE);

        foreach (VEC[k]) begin
            @(negedge clk);
            le_n    = VEC[k][13];
            sel     = VEC[k][12:10];
            oe_hi   = VEC[k][9];
            oe_lo_n = VEC[k][8];
            @(posedge clk); #2;
            checks++;
            if (y_n !== VEC[k][7:0]) begin
                fails++;
                $display("FAIL R%0d vector %0d: y_n=%h expected %h",
                         VEC[k][17:14], k, y_n, VEC[k][7:0]);
            end
        end

        // R2 sweep of every address
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            le_n = 1'b0; sel = 3'(i); oe_hi = 1'b1; oe_lo_n = 1'b0;
            @(posedge clk); #2;
            check("R2 sweep", y_n, ~(8'd1 << i));
        end

        // R6 and R7 act within the cycle, no edge needed
        @(negedge clk);
        le_n = 1'b1; oe_hi = 1'b0; #1;
        check("R6 same cycle", y_n, 8'hFF);
        oe_hi = 1'b1; #1;
        check("R8 release", y_n, 8'h7F);
        oe_lo_n = 1'b1; #1;
        check("R7 same cycle", y_n, 8'hFF);
        oe_lo_n = 1'b0;

        // R1 reset again clears the store
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #2;
        check("R1 reset again", y_n, 8'hFF);
        @(negedge clk);
        rst = 1'b0; sel = 3'd5;
        @(posedge clk); #2;
        check("R1 cleared store", y_n, 8'hFE);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule